// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This block produces the interrupt and DMA request lines for a synchronous serial port with an eight-entry receive FIFO and an eight-entry transmit FIFO. The FIFOs, the shifter and the bit-clock generator live elsewhere. This unit sees only the following inputs:

- the two FIFO fill counts;
- a strobe when a frame has been fully received;
- a strobe when the receive FIFO is read;
- a tick once per serial bit period;
- a small register write port.

It keeps two sticky events and two level flags, and gates them with a mask. The sticky events are receive overrun and receive time-out. The level flags are receive FIFO at least half full and transmit FIFO at least half empty. The masked flags are combined into one interrupt line.

Software reads five locations through a combinational read port:

- address 0: raw flags;
- address 1: mask;
- address 2: masked flags;
- address 3: clear register, which is write-only and reads as zero;
- address 4: DMA enables.

The two sticky events are cleared by writing 1 to the matching bit of the clear register. The level flags follow the FIFO counts directly and need no clear.

Top module: `serial_irq_unit`

## Requirements
- R1: Reading address 0 returns the raw flags: bit 0 overrun, bit 1 time-out, bit 2 receive-half-full, bit 3 transmit-half-empty.
- R2: When frameDone is high in a cycle with rxLevel equal to 8, the overrun flag reads 1 from the next cycle on and stays set until cleared.
- R3: A time-out counter counts bitTick pulses while rxLevel is non-zero. It restarts on rxRead or frameDone and is held at zero while rxLevel is 0. The time-out flag sets in the cycle after the 32nd uninterrupted tick and stays set until cleared.
- R4: The mask register sits at address 1 and resets to 0. Address 2 reads the raw flags ANDed bitwise with the mask.
- R5: Address 3 is write-only and reads 0. Writing bit 0 as 1 clears overrun, and writing bit 1 as 1 clears time-out. Bits 2 and 3 of that write have no effect.
- R6: If a flag's set event and its clear write occur in the same cycle, the flag ends up set.
- R7: After reset with txLevel 0 and rxLevel 0, the raw flags read 4'b1000.
- R8: The DMA enable register sits at address 4 and resets to 0; bit 0 enables receive and bit 1 enables transmit. rxDmaReq is high when the receive enable is set and rxLevel is at least 4. txDmaReq is high when the transmit enable is set and txLevel is at most 4.
- R9: irqOut is the OR of the four masked flags.
- R10: The two level flags follow the FIFO counts in the same cycle, with no stored state: bit 2 is rxLevel >= 4 and bit 3 is txLevel <= 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One pulse per serial bit period |
| rxLevel | input | 4 | Receive FIFO fill count, 0 to 8 |
| txLevel | input | 4 | Transmit FIFO fill count, 0 to 8 |
| frameDone | input | 1 | A frame finished arriving |
| rxRead | input | 1 | Receive FIFO read strobe |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address, used for both reads and writes |
| regWrData | input | 4 | Register write data |
| regRdData | output | 4 | Register read data |
| irqOut | output | 1 | Combined interrupt |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
The hardest case to reach from the ports is a time-out set that lands in the same cycle as a clear write. It needs exactly 31 uninterrupted ticks with the receive FIFO non-empty, and then a tick together with the clear. The bench drives one tick every cycle with a fixed non-zero level and counts the ticks itself, so it can place the clear on the precise cycle. It reaches the overrun version of the same race by holding the receive count at 8 while pulsing frameDone together with the clear write. A behavioural model runs beside the design and compares every output on every cycle.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int FLAG_OVR = 0;
  localparam int FLAG_TMO = 1;
  localparam int FLAG_RXH = 2;
  localparam int FLAG_TXH = 3;
  localparam int NFLAGS   = 4;

  typedef struct packed {
    logic clrOvr;
    logic clrTmo;
  } clrStrobes_t;
endpackage

// File: rtl/sirq_datapath.sv
module sirq_datapath
  import sirq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int TIMEOUT = 32,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int CNT_W  = $clog2(TIMEOUT + 1),
  localparam int HALF   = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic              frameDone,
  input  logic              rxRead,
  input  clrStrobes_t       strobes,
  output logic [NFLAGS-1:0] rawStat
);
  logic [CNT_W-1:0] tmoCnt;
  logic ovrFlag, tmoFlag;
  logic rxFull, restart, tmoHit, ovrHit;

  assign rxFull  = (rxLevel == LVL_W'(DEPTH));
  assign restart = rxRead || frameDone || (rxLevel == '0);
  assign tmoHit  = !restart && bitTick && (tmoCnt == CNT_W'(TIMEOUT - 1));
  assign ovrHit  = frameDone && rxFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmoCnt <= '0;
    end else if (restart) begin
      tmoCnt <= '0;
    end else if (bitTick && (tmoCnt < CNT_W'(TIMEOUT))) begin
      tmoCnt <= tmoCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovrFlag <= 1'b0;
      tmoFlag <= 1'b0;
    end else begin
      ovrFlag <= ovrHit || (ovrFlag && !strobes.clrOvr);
      tmoFlag <= tmoHit || (tmoFlag && !strobes.clrTmo);
    end
  end

  always_comb begin
    rawStat           = '0;
    rawStat[FLAG_OVR] = ovrFlag;
    rawStat[FLAG_TMO] = tmoFlag;
    rawStat[FLAG_RXH] = (rxLevel >= LVL_W'(HALF));
    rawStat[FLAG_TXH] = (txLevel <= LVL_W'(HALF));
  end

  // R2
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && rxFull) |=> rawStat[FLAG_OVR]);
  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rawStat[FLAG_OVR] && !strobes.clrOvr) |=> rawStat[FLAG_OVR]);
  // R6
  tmo_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tmoHit && strobes.clrTmo) |=> rawStat[FLAG_TMO]);
  // R3
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == '0) |=> (tmoCnt == '0));
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NFLAGS-1:0] regWrData,
  input  logic [NFLAGS-1:0] rawStat,
  output clrStrobes_t       strobes,
  output logic [NFLAGS-1:0] maskReg,
  output logic [1:0]        dmaEn,
  output logic [NFLAGS-1:0] regRdData
);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MIS  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DMA  = ADDR_W'(4);

  logic clrWr;
  assign clrWr          = regWrEn && (regAddr == A_CLR);
  assign strobes.clrOvr = clrWr && regWrData[FLAG_OVR];
  assign strobes.clrTmo = clrWr && regWrData[FLAG_TMO];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      dmaEn   <= '0;
    end else if (regWrEn) begin
      if (regAddr == A_MASK) maskReg <= regWrData;
      if (regAddr == A_DMA)  dmaEn   <= regWrData[1:0];
    end
  end

  always_comb begin
    unique case (regAddr)
      A_RAW:   regRdData = rawStat;
      A_MASK:  regRdData = maskReg;
      A_MIS:   regRdData = rawStat & maskReg;
      A_DMA:   regRdData = {2'b00, dmaEn};
      default: regRdData = '0;
    endcase
  end

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == A_MASK) |=> $stable(maskReg));
endmodule

// File: rtl/serial_irq_unit.sv
module serial_irq_unit
  import sirq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int TIMEOUT = 32,
  parameter int ADDR_W  = 3,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int HALF   = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic              frameDone,
  input  logic              rxRead,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NFLAGS-1:0] regWrData,
  output logic [NFLAGS-1:0] regRdData,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);
  clrStrobes_t       strobes;
  logic [NFLAGS-1:0] rawStat, maskReg;
  logic [1:0]        dmaEn;

  sirq_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rawStat(rawStat), .strobes(strobes),
    .maskReg(maskReg), .dmaEn(dmaEn), .regRdData(regRdData)
  );

  sirq_datapath #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) i_dp (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxLevel(rxLevel),
    .txLevel(txLevel), .frameDone(frameDone), .rxRead(rxRead),
    .strobes(strobes), .rawStat(rawStat)
  );

  assign irqOut   = |(rawStat & maskReg);
  assign rxDmaReq = dmaEn[0] && rawStat[FLAG_RXH];
  assign txDmaReq = dmaEn[1] && rawStat[FLAG_TXH];

  // R8
  rx_dma_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDmaReq |-> (rxLevel >= LVL_W'(HALF)));
  // R8
  tx_dma_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> (txLevel <= LVL_W'(HALF)));
endmodule

// File: tb/test_serial_irq_unit.sv
module test_serial_irq_unit;
  logic clk = 1'b0, rstN = 1'b0, bitTick = 1'b0, frameDone = 1'b0, rxRead = 1'b0;
  logic [3:0] rxLevel = '0, txLevel = '0, regWrData = '0, regRdData;
  logic [2:0] regAddr = '0;
  logic regWrEn = 1'b0, irqOut, rxDmaReq, txDmaReq;
  int checks = 0, errors = 0;
  bit done = 0;
  // reference model state
  bit mOvr = 0, mTmo = 0;
  int mCnt = 0;
  logic [3:0] mMask = '0;
  logic [1:0] mDma = '0;

  always #2.5 clk = ~clk;

  serial_irq_unit i_serial_irq_unit (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxLevel(rxLevel), .txLevel(txLevel),
    .frameDone(frameDone), .rxRead(rxRead), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  task automatic expect_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] modelRaw();
    return {txLevel <= 4, rxLevel >= 4, mTmo, mOvr};
  endfunction

  task automatic compareAll();
    logic [3:0] raw = modelRaw();
    logic [3:0] exp;
    string tag;
    case (regAddr)
      3'd0: begin exp = raw; tag = "R1"; end
      3'd1: begin exp = mMask; tag = "R4"; end
      3'd2: begin exp = raw & mMask; tag = "R4"; end
      3'd4: begin exp = {2'b00, mDma}; tag = "R8"; end
      default: begin exp = 4'h0; tag = "R5"; end
    endcase
    expect_eq(tag, regRdData, exp);
    expect_eq("R9", irqOut, |(raw & mMask));
    expect_eq("R8", rxDmaReq, mDma[0] && raw[2]);
    expect_eq("R8", txDmaReq, mDma[1] && raw[3]);
  endtask

  task automatic modelClock();
    bit restart = rxRead || frameDone || (rxLevel == 0);
    bit tmoSet = !restart && bitTick && (mCnt == 31);
    bit ovrSet = frameDone && (rxLevel == 8);
    if (!rstN) begin
      mOvr = 0; mTmo = 0; mCnt = 0; mMask = '0; mDma = '0;
      return;
    end
    if (restart) mCnt = 0;
    else if (bitTick && mCnt < 32) mCnt++;
    if (regWrEn && regAddr == 3'd1) mMask = regWrData;
    if (regWrEn && regAddr == 3'd4) mDma = regWrData[1:0];
    if (regWrEn && regAddr == 3'd3) begin
      if (regWrData[0]) mOvr = 0;
      if (regWrData[1]) mTmo = 0;
    end
    if (ovrSet) mOvr = 1;
    if (tmoSet) mTmo = 1;
  endtask

  // one cycle: settle, compare, clock edge, update model, back to negedge
  task automatic cyc();
    #1;
    if (rstN) compareAll();
    @(posedge clk);
    modelClock();
    @(negedge clk);
    regWrEn = 0; frameDone = 0; rxRead = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [3:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    cyc();
    regAddr = 3'd0;
  endtask

  task automatic peekRaw(string tag, logic [3:0] exp);
    regAddr = 3'd0;
    #0.5;
    expect_eq(tag, regRdData, exp);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    rstN = 1;
    // R7 reset values
    peekRaw("R7", 4'b1000);
    cyc();
    regAddr = 3'd1; cyc();
    regAddr = 3'd4; cyc();
    regAddr = 3'd3; cyc();
    // R10 level flags sweep
    for (int i = 0; i <= 8; i++) begin
      rxLevel = 4'(i); txLevel = 4'(8 - i);
      peekRaw("R10", {(8 - i) <= 4, i >= 4, 2'b00});
      cyc();
    end
    wr(3'd1, 4'hF);
    wr(3'd4, 4'h3);
    for (int i = 0; i <= 8; i++) begin
      rxLevel = 4'(8 - i); txLevel = 4'(i);
      regAddr = 3'(i % 5);
      cyc();
    end
    rxLevel = 0; txLevel = 8;
    wr(3'd1, 4'b0001);
    // R2 overrun at full
    rxLevel = 8; frameDone = 1; cyc();
    peekRaw("R2", 4'b0101);
    cyc(); cyc();
    peekRaw("R2", 4'b0101);
    // frame at level 7 is not an overrun; first clear
    wr(3'd3, 4'b0001);
    rxLevel = 7; frameDone = 1; cyc();
    peekRaw("R2", 4'b0100);
    // R5 clearing bits 2,3 has no effect on level flags
    rxLevel = 8; frameDone = 1; cyc();
    wr(3'd3, 4'b1100);
    peekRaw("R5", 4'b0101);
    // R6 overrun set and clear together
    frameDone = 1; regWrEn = 1; regAddr = 3'd3; regWrData = 4'b0011; cyc();
    peekRaw("R6", 4'b0101);
    wr(3'd3, 4'b0001);
    peekRaw("R5", 4'b0100);
    // R3 time-out
    wr(3'd1, 4'b0010);
    rxLevel = 2; bitTick = 1;
    repeat (20) cyc();
    rxRead = 1; cyc();
    repeat (31) cyc();
    peekRaw("R3", 4'b0000);
    cyc();
    peekRaw("R3", 4'b0010);
    repeat (5) cyc();
    wr(3'd3, 4'b0010);
    repeat (10) cyc();
    peekRaw("R3", 4'b0000);
    // empty holds counter at zero
    rxLevel = 0; repeat (40) cyc();
    rxLevel = 1; repeat (31) cyc();
    peekRaw("R3", 4'b0000);
    // R6 time-out set and clear on the same cycle (32nd tick)
    regWrEn = 1; regAddr = 3'd3; regWrData = 4'b0010; cyc();
    peekRaw("R6", 4'b0010);
    bitTick = 0;
    wr(3'd3, 4'b0010);
    wr(3'd4, 4'h1);
    rxLevel = 5; txLevel = 3;
    for (int i = 0; i < 5; i++) begin regAddr = 3'(i); cyc(); end
    rxLevel = 0; txLevel = 0;
    repeat (3) cyc();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule